// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that runs from an internal tick. A prescaler selects the tick rate. On every tick the counter is compared with a programmable period value. When the two are equal, the block raises a single-cycle match pulse and the counter starts again from zero on the next edge. So a period value of P gives a repeat interval of P+1 ticks. The match pulse is unscaled, and other logic can use it as a time base or as a shift clock.

A 4-bit postscaler counts match pulses. It sets a sticky event flag once every N matches, where N is between 1 and 16. The interrupt line is the flag gated by an enable input, and software clears the flag with a one-cycle strobe.

The count, the period and a 7-bit control word are loaded through separate write strobes. A count write or a control write restarts both the prescaler and the postscaler. A control write leaves the count untouched.

Top module: `pmt_timer`

## Requirements
- R1: After reset the count is 0x00, the period is 0xFF, the flag, match and interrupt outputs are low, and the control word is all zeros (stopped, 1:1, 1:1).
- R2: While the control run bit (ctl_wdata[6]) is 1, the count rises by one on every prescaled tick. While the run bit is 0, the count and the prescaler hold their values.
- R3: The prescale code in ctl_wdata[5:4] sets the tick period: code 00 gives one clock per tick, 01 gives four, and 10 or 11 gives sixteen.
- R4: In a cycle that holds a tick with count equal to period, match_o is high for that cycle only and the count is 0x00 after the edge. A period value of P therefore repeats every P+1 ticks.
- R5: The postscale code k in ctl_wdata[3:0] sets flag_o on the (k+1)-th match since the postscaler was last cleared, and the postscaler then starts again. The flag stays set until it is cleared.
- R6: A flag_clr strobe clears the flag at the next edge. If a flag-setting match falls in the same cycle, the set wins.
- R7: irq_o equals flag_o ANDed with irq_en at all times.
- R8: A count write loads cnt_wdata into the count at the next edge, ahead of any increment, and clears the prescaler and the postscaler.
- R9: A control write clears the prescaler and the postscaler, blocks any tick in that cycle, and leaves the count unchanged.
- R10: If the period is set below the current count, the count keeps rising, wraps from 0xFF to 0x00, and then matches the period normally.
- R11: A period write shows on period_o after the next edge and does not disturb the prescaler, the postscaler or the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value loaded into the count |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 8 | Value loaded into the period |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 7 | Control word: [6] run, [5:4] prescale code, [3:0] postscale code |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| count_o | output | 8 | Current count |
| period_o | output | 8 | Current period |
| match_o | output | 1 | Unscaled match pulse |
| flag_o | output | 1 | Sticky postscaled event flag |
| irq_o | output | 1 | Flag gated by irq_en |

## Verification
The assertions assume three things about the inputs:
- every strobe and data input is synchronous to clk;
- the prescale and postscale codes change only through a control write, which also clears both scaler counters;
- a prescaled tick is never followed at once by another tick unless the ratio is 1:1.

The stimulus drives every input one time unit after the rising edge and holds each strobe for exactly one cycle, so these assumptions always hold. The directed sequences cover each prescale code, a postscale ratio of three, a period set below the running count, and the write orderings. A cycle-by-cycle scoreboard compares all outputs against a model built from the requirements.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int CNT_W      = 8;
  localparam int POST_W     = 4;
  localparam int PRE_CNT_W  = 4;
  localparam int PRE_CODE_W = 2;

  // control word: [6] run, [5:4] prescale code, [3:0] postscale code
  typedef struct packed {
    logic                  run;
    logic [PRE_CODE_W-1:0] pre_sel;
    logic [POST_W-1:0]     post_sel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/pmt_rst_sync.sv
module pmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmt_prescale.sv
module pmt_prescale #(
  parameter int PRE_CNT_W  = pmt_pkg::PRE_CNT_W,
  parameter int PRE_CODE_W = pmt_pkg::PRE_CODE_W
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  run,
  input  logic                  clr,
  input  logic [PRE_CODE_W-1:0] sel,
  output logic                  tick
);
  localparam int STEP = PRE_CNT_W / 2;
  localparam logic [PRE_CNT_W-1:0] LIM_MID = PRE_CNT_W'((1 << STEP) - 1);
  localparam logic [PRE_CNT_W-1:0] LIM_MAX = PRE_CNT_W'((1 << PRE_CNT_W) - 1);

  logic [PRE_CNT_W-1:0] pre_q, pre_d, lim_m1;
  logic                 wrap;

  always_comb begin
    unique case (sel)
      2'b00:   lim_m1 = '0;
      2'b01:   lim_m1 = LIM_MID;
      default: lim_m1 = LIM_MAX;
    endcase
  end

  assign wrap = (pre_q == lim_m1);
  assign tick = run & ~clr & wrap;

  always_comb begin
    pre_d = pre_q;
    if (clr)       pre_d = '0;
    else if (run)  pre_d = wrap ? '0 : pre_q + PRE_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  // R9
  pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (pre_q == '0));

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && (lim_m1 != '0)) |=> !tick);

  // R2
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/pmt_count.sv
module pmt_count #(
  parameter int CNT_W = pmt_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic             equal;

  assign equal = (cnt_q == per_q);
  assign match = tick & equal;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)     cnt_d = cnt_wdata;
    else if (tick)  cnt_d = equal ? '0 : cnt_q + CNT_W'(1);
  end

  always_comb begin
    per_d = per_q;
    if (per_wr) per_d = per_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign count  = cnt_q;
  assign period = per_q;

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (match && !cnt_wr) |=> (cnt_q == '0));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));

  // R11
  per_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    per_wr |=> (per_q == $past(per_wdata)));
endmodule

// File: rtl/pmt_postscale.sv
module pmt_postscale #(
  parameter int POST_W = pmt_pkg::POST_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              match,
  input  logic              clr,
  input  logic [POST_W-1:0] sel,
  input  logic              flag_clr,
  output logic              flag
);
  logic [POST_W-1:0] post_q, post_d;
  logic              flag_q, flag_d, last, set;

  assign last = (post_q == sel);
  assign set  = match & last;

  always_comb begin
    post_d = post_q;
    if (clr)        post_d = '0;
    else if (match) post_d = last ? '0 : post_q + POST_W'(1);
  end

  always_comb begin
    flag_d = flag_q;
    if (set)           flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q <= '0;
      flag_q <= 1'b0;
    end else begin
      post_q <= post_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  // R9
  post_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    clr |=> (post_q == '0));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_clr && !set) |=> !flag_q);

  // R6
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> flag_q);
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
  import pmt_pkg::*;
#(
  parameter int TW = pmt_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_wr,
  input  logic [TW-1:0] cnt_wdata,
  input  logic          per_wr,
  input  logic [TW-1:0] per_wdata,
  input  logic          ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic [TW-1:0] count_o,
  output logic [TW-1:0] period_o,
  output logic          match_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic rst_ni;
  ctl_t ctl_q, ctl_d;
  logic scaler_clr, tick, match, flag;

  pmt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) ctl_d = ctl_t'(ctl_wdata);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign scaler_clr = cnt_wr | ctl_wr;

  pmt_prescale #(.PRE_CNT_W(PRE_CNT_W), .PRE_CODE_W(PRE_CODE_W)) u_pre (
    .clk(clk), .rst_ni(rst_ni), .run(ctl_q.run), .clr(scaler_clr),
    .sel(ctl_q.pre_sel), .tick(tick)
  );

  pmt_count #(.CNT_W(TW)) u_cnt (
    .clk(clk), .rst_ni(rst_ni), .tick(tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .per_wr(per_wr), .per_wdata(per_wdata),
    .count(count_o), .period(period_o), .match(match)
  );

  pmt_postscale #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst_ni(rst_ni), .match(match), .clr(scaler_clr),
    .sel(ctl_q.post_sel), .flag_clr(flag_clr), .flag(flag)
  );

  assign match_o = match;
  assign flag_o  = flag;
  assign irq_o   = flag & irq_en;

  // R9
  ctl_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_wr && !cnt_wr) |=> $stable(count_o));

  // R4
  match_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (match_o && !cnt_wr && (period_o != '0)) |=> !match_o);
endmodule

// File: tb/pmt_timer_test.sv
module pmt_timer_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cnt_wr, per_wr, ctl_wr, irq_en, flag_clr;
  logic [7:0] cnt_wd, per_wd;
  logic [6:0] ctl_wd;
  logic [7:0] count_o, period_o;
  logic match_o, flag_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit model_on = 0;

  typedef struct {
    int cnt; int per; bit flag; int pre; int post; bit run; int psel; int osel;
  } exp_t;
  exp_t m, nx, e;
  exp_t sbq[$];

  always #4 clk = ~clk;

  pmt_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wd),
    .per_wr(per_wr), .per_wdata(per_wd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wd),
    .irq_en(irq_en), .flag_clr(flag_clr), .count_o(count_o),
    .period_o(period_o), .match_o(match_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ratio(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  function automatic logic [6:0] cw(input bit run, input int pre, input int post);
    return {run, 2'(pre), 4'(post)};
  endfunction

  // reference model: advances on each edge and queues the expected state
  always @(posedge clk) begin
    if (model_on) begin
      int lim; bit clr, tk, mt;
      lim = ratio(m.psel);
      clr = cnt_wr | ctl_wr;
      tk  = m.run && !clr && (m.pre == lim - 1);
      mt  = tk && (m.cnt == m.per);
      nx  = m;
      if (clr) nx.pre = 0;
      else if (m.run) nx.pre = (m.pre == lim - 1) ? 0 : m.pre + 1;
      if (clr) nx.post = 0;
      else if (mt) nx.post = (m.post == m.osel) ? 0 : m.post + 1;
      if (mt && m.post == m.osel) nx.flag = 1;
      else if (flag_clr) nx.flag = 0;
      if (cnt_wr) nx.cnt = cnt_wd;
      else if (tk) nx.cnt = mt ? 0 : (m.cnt + 1) % 256;
      if (per_wr) nx.per = per_wd;
      if (ctl_wr) begin
        nx.run = ctl_wd[6]; nx.psel = ctl_wd[5:4]; nx.osel = ctl_wd[3:0];
      end
      m = nx;
      sbq.push_back(nx);
    end
  end

  // monitor: pops the expected state and compares away from the edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      bit em;
      e  = sbq.pop_front();
      em = e.run && !(cnt_wr | ctl_wr) && (e.pre == ratio(e.psel) - 1) && (e.cnt == e.per);
      chk(count_o == 8'(e.cnt), "R2 scoreboard count", count_o, e.cnt);
      chk(period_o == 8'(e.per), "R11 scoreboard period", period_o, e.per);
      chk(flag_o == e.flag, "R5 scoreboard flag", flag_o, e.flag);
      chk(match_o == em, "R4 scoreboard match", match_o, em);
      chk(irq_o == (e.flag & irq_en), "R7 scoreboard irq", irq_o, e.flag & irq_en);
    end
  end

  task automatic wr_cnt(input logic [7:0] v);
    @(posedge clk); #1 cnt_wr = 1; cnt_wd = v;
    @(posedge clk); #1 cnt_wr = 0;
  endtask
  task automatic wr_per(input logic [7:0] v);
    @(posedge clk); #1 per_wr = 1; per_wd = v;
    @(posedge clk); #1 per_wr = 0;
  endtask
  task automatic wr_ctl(input logic [6:0] v, input bit also_clr);
    @(posedge clk); #1 ctl_wr = 1; ctl_wd = v; flag_clr = also_clr;
    @(posedge clk); #1 ctl_wr = 0; flag_clr = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int a, c0, g, n;
    bit saw_ff;
    rst_n = 0; cnt_wr = 0; per_wr = 0; ctl_wr = 0; irq_en = 0; flag_clr = 0;
    cnt_wd = 0; per_wd = 0; ctl_wd = 0;
    m = '{cnt:0, per:255, flag:0, pre:0, post:0, run:0, psel:0, osel:0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // R1 reset state
    chk(count_o == 8'h00, "R1 count", count_o, 0);
    chk(period_o == 8'hFF, "R1 period", period_o, 8'hFF);
    chk(flag_o == 0, "R1 flag", flag_o, 0);
    chk(match_o == 0, "R1 match", match_o, 0);
    chk(irq_o == 0, "R1 irq", irq_o, 0);

    // R2 stopped timer holds
    repeat (5) @(negedge clk);
    chk(count_o == 8'h00, "R2 held while stopped", count_o, 0);

    // R11 period write
    wr_per(8'h21);
    @(negedge clk);
    chk(period_o == 8'h21, "R11 period load", period_o, 8'h21);

    // R8 count write
    wr_cnt(8'h40);
    @(negedge clk);
    chk(count_o == 8'h40, "R8 count load", count_o, 8'h40);

    // R2 increments at 1:1
    wr_per(8'hFF);
    wr_ctl(cw(1, 0, 0), 0);
    @(negedge clk); a = count_o;
    @(negedge clk);
    chk(count_o == 8'(a + 1), "R2 increment", count_o, 8'(a + 1));

    // R9 control write keeps count
    @(posedge clk); #1 c0 = count_o; ctl_wr = 1; ctl_wd = cw(1, 0, 0);
    @(posedge clk); #1 ctl_wr = 0;
    @(negedge clk);
    chk(count_o == 8'(c0), "R9 count unchanged", count_o, c0);

    // R3 and R4: match interval for each prescale code
    for (int code = 0; code < 4; code++) begin
      wr_per(8'd3);
      wr_ctl(cw(1, code, 0), 0);
      wr_cnt(8'd0);
      g = 0;
      while (!match_o && g < 2000) begin @(negedge clk); g++; end
      chk(count_o == 8'd3, "R4 count at match", count_o, 3);
      @(negedge clk);
      chk(count_o == 8'd0, "R4 restart at zero", count_o, 0);
      g = 1;
      while (!match_o && g < 2000) begin @(negedge clk); g++; end
      chk(g == 4 * ratio(code), "R3 match interval", g, 4 * ratio(code));
    end

    // R5 postscale 1:3
    wr_per(8'd3);
    wr_ctl(cw(1, 0, 2), 1);
    n = 0; g = 0;
    while (!flag_o && g < 2000) begin
      @(negedge clk); g++;
      if (!flag_o && match_o) n++;
    end
    chk(n == 3, "R5 matches before flag", n, 3);

    // R6 and R7
    wr_per(8'hFF);
    wr_cnt(8'd0);
    @(negedge clk);
    chk(flag_o == 1, "R5 flag sticky", flag_o, 1);
    chk(irq_o == 0, "R7 irq masked", irq_o, 0);
    @(posedge clk); #1 irq_en = 1;
    @(negedge clk);
    chk(irq_o == 1, "R7 irq enabled", irq_o, 1);
    @(posedge clk); #1 flag_clr = 1;
    @(posedge clk); #1 flag_clr = 0;
    @(negedge clk);
    chk(flag_o == 0, "R6 flag cleared", flag_o, 0);
    chk(irq_o == 0, "R7 irq after clear", irq_o, 0);

    // R10 period below count wraps
    wr_per(8'd5);
    wr_cnt(8'd10);
    saw_ff = 0; g = 0;
    while (!match_o && g < 600) begin
      @(negedge clk); g++;
      if (count_o == 8'hFF) saw_ff = 1;
    end
    chk(count_o == 8'd5 && saw_ff, "R10 wrap then match", {saw_ff, count_o}, {1'b1, 8'd5});

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule